// File: doc/BRIEF.md
# Register Rename Map Table

This block translates architectural register numbers into physical register numbers for an out-of-order core. The caller gives one unified architectural index. Integer registers come first in that index space, floating-point registers follow, and miscellaneous registers come last. The block decodes which class the index belongs to and uses the index relative to that class. Integer and floating-point registers each have their own map table and their own free list of physical registers. Miscellaneous registers are never renamed: each one has a fixed physical number placed above the whole physical file.

A rename request is answered in the same cycle it is presented. The block returns the newly allocated physical register and the mapping it replaced, so the caller can free the replaced register when the instruction retires. The table and free-list updates take effect at the following clock edge. A combinational lookup port reads the current mapping. A set port lets commit or squash logic write a mapping back. Freed physical registers are pushed into the free list of their class. The block reports the smaller of the two free-list counts as its free capacity. When a set and a rename hit the same entry in the same cycle, the set wins.

Top module: `reg_rename_map`

## Requirements
- R1: A rename of an integer or floating-point register that is not a zero register returns, in the same cycle, `ren_new` equal to the head of its class's free list and `ren_prev` equal to the mapping held before the request. From the next cycle the table holds `ren_new`.
- R2: A rename of the integer zero register (unified index 0) or the floating-point zero register (unified index 15) returns that register's reset physical number (0 or 23) as both `ren_new` and `ren_prev`. It takes nothing from a free list and leaves the table unchanged.
- R3: With default parameters, unified indices 0..7 are integer, 8..15 are floating-point and 16..19 are miscellaneous. The relative index is the unified index minus the first index of its class.
- R4: A miscellaneous rename or lookup returns 32 plus the relative miscellaneous index, which is the total physical count plus that index. A rename reports the same value as `ren_prev` and changes no free count.
- R5: Integer renames pop only the integer free list, which holds physical 8..15 at reset. Floating-point renames pop only the floating-point free list, which holds physical 24..31 at reset. Floating-point physical numbers lie in 16..31, above the integer numbers 0..15.
- R6: A set on a miscellaneous register changes no state. `set_err` is high in that cycle when `set_phys` differs from the fixed mapping and low when it matches.
- R7: `free_count` equals the smaller of the integer and floating-point free-list counts. It is 8 after reset.
- R8: After reset, integer register r maps to physical r, and floating-point relative register f maps to physical 16+f.
- R9: A unified index of 20 or more raises `ren_err` (when `ren_valid` is high) or `set_err` (when `set_valid` is high). It changes no table entry and no free count.
- R10: `ren_ready` is low while the index is a non-zero register of a class whose free list is empty. A request held in that state changes neither the table nor the free count. Other classes and the zero registers stay ready.
- R11: A lookup in the same cycle as a rename of the same register returns the old mapping. The new mapping is visible from the next cycle.
- R12: A register freed into a list can be allocated from the next cycle onward. Allocation follows first-in first-out order, and each list holds physical count minus architectural count entries (8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ren_valid | input | 1 | Rename request valid |
| ren_arch | input | 5 | Unified architectural index to rename |
| ren_ready | output | 1 | Free list needed by `ren_arch` is not empty |
| ren_new | output | 6 | Newly assigned physical register |
| ren_prev | output | 6 | Physical register mapped before the request |
| ren_err | output | 1 | Rename index out of range |
| lk_arch | input | 5 | Unified architectural index to look up |
| lk_phys | output | 6 | Current physical mapping (0 for out-of-range) |
| set_valid | input | 1 | Set request valid |
| set_arch | input | 5 | Unified architectural index to overwrite |
| set_phys | input | 6 | Physical register to write |
| set_err | output | 1 | Set index out of range or miscellaneous mismatch |
| free_int_valid | input | 1 | Push a register into the integer free list |
| free_int_phys | input | 6 | Integer physical register being freed |
| free_fp_valid | input | 1 | Push a register into the floating-point free list |
| free_fp_phys | input | 6 | Floating-point physical register being freed |
| free_count | output | 4 | Minimum of the two free-list counts |

## Verification
A corrupted table entry appears on `lk_phys` in the cycle after the faulty write. It also appears on `ren_prev` at the next rename of that register. A free-list pointer or count that drifts shows up at once as an unexpected `ren_new` value, or as a `free_count` that no longer matches the bench's own tally. A wrong class decode sends a rename to the wrong list, and `ren_new` lands outside its class range in the same cycle. The directed tests drain one list completely and refill it. This exposes mistakes in readiness and in first-in first-out order within a few cycles.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2,
    CLS_BAD  = 2'd3
  } reg_class_e;
endpackage

// File: rtl/rm_class_decode.sv
module rm_class_decode
  import rm_pkg::*;
#(
  parameter int INT_ARCH  = 8,
  parameter int FP_ARCH   = 8,
  parameter int MISC_ARCH = 4,
  parameter int AW        = 5
) (
  input  logic [AW-1:0] arch_idx,
  output reg_class_e    cls,
  output logic [AW-1:0] rel_idx
);
  localparam logic [AW:0] LIM_INT  = (AW+1)'(INT_ARCH);
  localparam logic [AW:0] LIM_FP   = (AW+1)'(INT_ARCH + FP_ARCH);
  localparam logic [AW:0] LIM_MISC = (AW+1)'(INT_ARCH + FP_ARCH + MISC_ARCH);

  logic [AW:0] ext_idx;
  logic [AW:0] rel_ext;

  always_comb begin
    ext_idx = {1'b0, arch_idx};
    if (ext_idx < LIM_INT) begin
      cls     = CLS_INT;
      rel_ext = ext_idx;
    end else if (ext_idx < LIM_FP) begin
      cls     = CLS_FP;
      rel_ext = ext_idx - LIM_INT;
    end else if (ext_idx < LIM_MISC) begin
      cls     = CLS_MISC;
      rel_ext = ext_idx - LIM_FP;
    end else begin
      cls     = CLS_BAD;
      rel_ext = '0;
    end
    rel_idx = rel_ext[AW-1:0];
  end
endmodule

// File: rtl/rm_map_table.sv
module rm_map_table #(
  parameter int N    = 8,
  parameter int PW   = 6,
  parameter int BASE = 0,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_data,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [PW-1:0] set_data,
  input  logic [IW-1:0] rd_a_idx,
  output logic [PW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [PW-1:0] rd_b_data
);
  logic [PW-1:0] ent_q [N];
  logic [PW-1:0] ent_d [N];
  logic [N-1:0]  ent_en;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_en[i] = 1'b0;
      ent_d[i]  = ent_q[i];
      if (wr_en && (wr_idx == IW'(i))) begin
        ent_en[i] = 1'b1;
        ent_d[i]  = wr_data;
      end
      if (set_en && (set_idx == IW'(i))) begin
        ent_en[i] = 1'b1;
        ent_d[i]  = set_data;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= PW'(BASE + g);
      end else if (ent_en[g]) begin
        ent_q[g] <= ent_d[g];
      end
    end
  end

  assign rd_a_data = ent_q[rd_a_idx];
  assign rd_b_data = ent_q[rd_b_idx];

  // R11: a write becomes visible on the read port one cycle later
  a_r11_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_en) |=> (ent_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/rm_free_list.sv
module rm_free_list #(
  parameter int DEPTH     = 8,
  parameter int PW        = 6,
  parameter int FILL_BASE = 8,
  localparam int PTRW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_data,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty
);
  localparam logic [CW-1:0]   FULL_CNT = CW'(DEPTH);
  localparam logic [PTRW-1:0] LAST_PTR = PTRW'(DEPTH - 1);

  logic [PW-1:0]   slot_q [DEPTH];
  logic [PTRW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            do_push, do_pop;

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != FULL_CNT) || do_pop);
    rd_d    = rd_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    if (do_pop)  rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + PTRW'(1);
    if (do_push) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + PTRW'(1);
    if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
    if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= FULL_CNT;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= PW'(FILL_BASE + g);
      end else if (do_push && (wr_q == PTRW'(g))) begin
        slot_q[g] <= push_data;
      end
    end
  end

  assign head  = slot_q[rd_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);

  // R12: never push into a full list
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((cnt_q != FULL_CNT) || pop));
  // R10: never pop an empty list
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  // R12: a lone pop lowers the count by exactly one
  a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/reg_rename_map.sv
module reg_rename_map
  import rm_pkg::*;
#(
  parameter int INT_ARCH   = 8,
  parameter int FP_ARCH    = 8,
  parameter int MISC_ARCH  = 4,
  parameter int INT_PHYS   = 16,
  parameter int FP_PHYS    = 16,
  parameter int INT_ZERO   = 0,
  parameter bit FP_ZERO_EN = 1'b1,
  parameter int FP_ZERO    = 7,
  localparam int AW        = $clog2(INT_ARCH + FP_ARCH + MISC_ARCH),
  localparam int PW        = $clog2(INT_PHYS + FP_PHYS + MISC_ARCH),
  localparam int INT_DEPTH = INT_PHYS - INT_ARCH,
  localparam int FP_DEPTH  = FP_PHYS - FP_ARCH,
  localparam int CW        = $clog2(((INT_DEPTH > FP_DEPTH) ? INT_DEPTH : FP_DEPTH) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  output logic          ren_ready,
  output logic [PW-1:0] ren_new,
  output logic [PW-1:0] ren_prev,
  output logic          ren_err,
  input  logic [AW-1:0] lk_arch,
  output logic [PW-1:0] lk_phys,
  input  logic          set_valid,
  input  logic [AW-1:0] set_arch,
  input  logic [PW-1:0] set_phys,
  output logic          set_err,
  input  logic          free_int_valid,
  input  logic [PW-1:0] free_int_phys,
  input  logic          free_fp_valid,
  input  logic [PW-1:0] free_fp_phys,
  output logic [CW-1:0] free_count
);
  localparam int IIW = (INT_ARCH > 1) ? $clog2(INT_ARCH) : 1;
  localparam int FIW = (FP_ARCH > 1) ? $clog2(FP_ARCH) : 1;
  localparam int ICW = $clog2(INT_DEPTH + 1);
  localparam int FCW = $clog2(FP_DEPTH + 1);
  localparam logic [PW-1:0] MISC_BASE = PW'(INT_PHYS + FP_PHYS);
  localparam logic [PW-1:0] INT_ZPHYS = PW'(INT_ZERO);
  localparam logic [PW-1:0] FP_ZPHYS  = PW'(INT_PHYS + FP_ZERO);
  localparam logic [PW-1:0] FP_LO     = PW'(INT_PHYS);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  reg_class_e    r_cls, l_cls, s_cls;
  logic [AW-1:0] r_rel, l_rel, s_rel;

  rm_class_decode #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .MISC_ARCH(MISC_ARCH), .AW(AW))
    u_dec_ren (.arch_idx(ren_arch), .cls(r_cls), .rel_idx(r_rel));
  rm_class_decode #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .MISC_ARCH(MISC_ARCH), .AW(AW))
    u_dec_lk  (.arch_idx(lk_arch),  .cls(l_cls), .rel_idx(l_rel));
  rm_class_decode #(.INT_ARCH(INT_ARCH), .FP_ARCH(FP_ARCH), .MISC_ARCH(MISC_ARCH), .AW(AW))
    u_dec_set (.arch_idx(set_arch), .cls(s_cls), .rel_idx(s_rel));

  logic          r_zero_int, r_zero_fp, r_zero;
  logic          int_pop, fp_pop, int_empty, fp_empty;
  logic [PW-1:0] int_head, fp_head;
  logic [ICW-1:0] int_cnt;
  logic [FCW-1:0] fp_cnt;
  logic [PW-1:0] int_prev, fp_prev, int_lk, fp_lk;
  logic [PW-1:0] r_misc_phys, l_misc_phys, s_misc_phys;

  always_comb begin
    r_zero_int  = (r_cls == CLS_INT) && (r_rel == AW'(INT_ZERO));
    r_zero_fp   = FP_ZERO_EN && (r_cls == CLS_FP) && (r_rel == AW'(FP_ZERO));
    r_zero      = r_zero_int || r_zero_fp;
    r_misc_phys = MISC_BASE + PW'(r_rel);
    l_misc_phys = MISC_BASE + PW'(l_rel);
    s_misc_phys = MISC_BASE + PW'(s_rel);

    ren_ready = !((r_cls == CLS_INT) && !r_zero && int_empty) &&
                !((r_cls == CLS_FP)  && !r_zero && fp_empty);
    int_pop   = ren_valid && (r_cls == CLS_INT) && !r_zero && !int_empty;
    fp_pop    = ren_valid && (r_cls == CLS_FP)  && !r_zero && !fp_empty;
    ren_err   = ren_valid && (r_cls == CLS_BAD);

    unique case (r_cls)
      CLS_INT: begin
        ren_new  = r_zero ? INT_ZPHYS : int_head;
        ren_prev = r_zero ? INT_ZPHYS : int_prev;
      end
      CLS_FP: begin
        ren_new  = r_zero ? FP_ZPHYS : fp_head;
        ren_prev = r_zero ? FP_ZPHYS : fp_prev;
      end
      CLS_MISC: begin
        ren_new  = r_misc_phys;
        ren_prev = r_misc_phys;
      end
      default: begin
        ren_new  = '0;
        ren_prev = '0;
      end
    endcase

    unique case (l_cls)
      CLS_INT:  lk_phys = int_lk;
      CLS_FP:   lk_phys = fp_lk;
      CLS_MISC: lk_phys = l_misc_phys;
      default:  lk_phys = '0;
    endcase

    set_err = set_valid && ((s_cls == CLS_BAD) ||
              ((s_cls == CLS_MISC) && (set_phys != s_misc_phys)));

    free_count = (CW'(int_cnt) < CW'(fp_cnt)) ? CW'(int_cnt) : CW'(fp_cnt);
  end

  rm_map_table #(.N(INT_ARCH), .PW(PW), .BASE(0)) u_int_tab (
    .clk(clk), .rst_n(rst_q),
    .wr_en(int_pop), .wr_idx(r_rel[IIW-1:0]), .wr_data(int_head),
    .set_en(set_valid && (s_cls == CLS_INT)), .set_idx(s_rel[IIW-1:0]), .set_data(set_phys),
    .rd_a_idx(r_rel[IIW-1:0]), .rd_a_data(int_prev),
    .rd_b_idx(l_rel[IIW-1:0]), .rd_b_data(int_lk)
  );

  rm_map_table #(.N(FP_ARCH), .PW(PW), .BASE(INT_PHYS)) u_fp_tab (
    .clk(clk), .rst_n(rst_q),
    .wr_en(fp_pop), .wr_idx(r_rel[FIW-1:0]), .wr_data(fp_head),
    .set_en(set_valid && (s_cls == CLS_FP)), .set_idx(s_rel[FIW-1:0]), .set_data(set_phys),
    .rd_a_idx(r_rel[FIW-1:0]), .rd_a_data(fp_prev),
    .rd_b_idx(l_rel[FIW-1:0]), .rd_b_data(fp_lk)
  );

  rm_free_list #(.DEPTH(INT_DEPTH), .PW(PW), .FILL_BASE(INT_ARCH)) u_int_fl (
    .clk(clk), .rst_n(rst_q),
    .push(free_int_valid), .push_data(free_int_phys),
    .pop(int_pop), .head(int_head), .count(int_cnt), .empty(int_empty)
  );

  rm_free_list #(.DEPTH(FP_DEPTH), .PW(PW), .FILL_BASE(INT_PHYS + FP_ARCH)) u_fp_fl (
    .clk(clk), .rst_n(rst_q),
    .push(free_fp_valid), .push_data(free_fp_phys),
    .pop(fp_pop), .head(fp_head), .count(fp_cnt), .empty(fp_empty)
  );

  // R5: an accepted integer allocation lies below the floating-point range
  a_r5_int_range: assert property (@(posedge clk) disable iff (!rst_q)
    (ren_valid && ren_ready && (r_cls == CLS_INT) && !r_zero) |-> (ren_new < FP_LO));
  // R5: an accepted floating-point allocation lies in its own range
  a_r5_fp_range: assert property (@(posedge clk) disable iff (!rst_q)
    (ren_valid && ren_ready && (r_cls == CLS_FP) && !r_zero) |->
      ((ren_new >= FP_LO) && (ren_new < MISC_BASE)));
  // R4: miscellaneous renames report matching new and previous numbers above the file
  a_r4_misc_fixed: assert property (@(posedge clk) disable iff (!rst_q)
    (ren_valid && (r_cls == CLS_MISC)) |-> ((ren_new == ren_prev) && (ren_new >= MISC_BASE)));
  // R2: a zero-register rename leaves the free capacity alone
  a_r2_zero_keeps_count: assert property (@(posedge clk) disable iff (!rst_q)
    (ren_valid && r_zero && !free_int_valid && !free_fp_valid) |=> $stable(free_count));
endmodule

// File: tb/reg_rename_map_bench.sv
module reg_rename_map_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, set_valid, free_int_valid, free_fp_valid;
  logic [4:0] ren_arch, lk_arch, set_arch;
  logic [5:0] set_phys, free_int_phys, free_fp_phys;
  logic       ren_ready, ren_err, set_err;
  logic [5:0] ren_new, ren_prev, lk_phys;
  logic [3:0] free_count;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  reg_rename_map u_reg_rename_map (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_ready(ren_ready),
    .ren_new(ren_new), .ren_prev(ren_prev), .ren_err(ren_err),
    .lk_arch(lk_arch), .lk_phys(lk_phys),
    .set_valid(set_valid), .set_arch(set_arch), .set_phys(set_phys), .set_err(set_err),
    .free_int_valid(free_int_valid), .free_int_phys(free_int_phys),
    .free_fp_valid(free_fp_valid), .free_fp_phys(free_fp_phys),
    .free_count(free_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // one rename: drive at negedge, check before the edge, commit, release
  task automatic rename_chk(input string req, input int arch, input int exp_new,
                            input int exp_prev);
    @(negedge clk);
    ren_valid = 1'b1;
    ren_arch  = 5'(arch);
    #2;
    check({req, " ready"}, int'(ren_ready), 1);
    check({req, " new"}, int'(ren_new), exp_new);
    check({req, " prev"}, int'(ren_prev), exp_prev);
    @(posedge clk);
    #1 ren_valid = 1'b0;
  endtask

  task automatic lookup_chk(input string req, input int arch, input int exp);
    @(negedge clk);
    lk_arch = 5'(arch);
    #2 check(req, int'(lk_phys), exp);
  endtask

  task automatic t_reset();
    for (int r = 0; r < 8; r++) lookup_chk("R8 int identity", r, r);
    for (int f = 0; f < 8; f++) lookup_chk("R8 fp identity", 8 + f, 16 + f);
    for (int m = 0; m < 4; m++) lookup_chk("R4 misc fixed lookup", 16 + m, 32 + m);
    check("R7 reset count", int'(free_count), 8);
  endtask

  task automatic t_int_rename();
    // R11: same-cycle lookup returns the old mapping
    @(negedge clk);
    ren_valid = 1'b1; ren_arch = 5'd3; lk_arch = 5'd3;
    #2;
    check("R11 same-cycle lookup", int'(lk_phys), 3);
    check("R1 int new", int'(ren_new), 8);
    check("R1 int prev", int'(ren_prev), 3);
    @(posedge clk);
    #1 ren_valid = 1'b0;
    lookup_chk("R11 next-cycle lookup", 3, 8);
    rename_chk("R1 R12 second int", 3, 9, 8);
    check("R5 int count only", int'(free_count), 6);
  endtask

  task automatic t_fp_rename();
    rename_chk("R5 R3 fp rename", 10, 24, 18);
    lookup_chk("R1 fp mapped", 10, 24);
    check("R7 min count", int'(free_count), 6);
  endtask

  task automatic t_zero();
    rename_chk("R2 int zero", 0, 0, 0);
    lookup_chk("R2 int zero table", 0, 0);
    rename_chk("R2 fp zero", 15, 23, 23);
    lookup_chk("R2 fp zero table", 15, 23);
    check("R2 count kept", int'(free_count), 6);
  endtask

  task automatic t_misc();
    rename_chk("R4 misc rename", 17, 33, 33);
    check("R4 count kept", int'(free_count), 6);
    @(negedge clk);
    set_valid = 1'b1; set_arch = 5'd17; set_phys = 6'd33;
    #2 check("R6 set match no err", int'(set_err), 0);
    @(posedge clk);
    #1 set_phys = 6'd5;
    @(negedge clk);
    #2 check("R6 set mismatch err", int'(set_err), 1);
    @(posedge clk);
    #1 set_valid = 1'b0;
    lookup_chk("R6 misc unchanged", 17, 33);
  endtask

  task automatic t_bad();
    @(negedge clk);
    ren_valid = 1'b1; ren_arch = 5'd25;
    #2 check("R9 rename err", int'(ren_err), 1);
    @(posedge clk);
    #1 ren_valid = 1'b0;
    @(negedge clk);
    #2 check("R9 no err when idle", int'(ren_err), 0);
    check("R9 count kept", int'(free_count), 6);
    @(negedge clk);
    set_valid = 1'b1; set_arch = 5'd22; set_phys = 6'd3;
    #2 check("R9 set err", int'(set_err), 1);
    @(posedge clk);
    #1 set_valid = 1'b0;
    lookup_chk("R9 int table kept", 3, 9);
    lookup_chk("R9 fp table kept", 14, 22);
  endtask

  task automatic t_set();
    @(negedge clk);
    set_valid = 1'b1; set_arch = 5'd3; set_phys = 6'd3;
    #2 check("R3 set int no err", int'(set_err), 0);
    @(posedge clk);
    #1 set_valid = 1'b0;
    lookup_chk("R3 set restored", 3, 3);
  endtask

  task automatic t_drain_refill();
    for (int k = 1; k <= 6; k++) rename_chk("R12 drain order", k, 9 + k, (k == 3) ? 3 : k);
    check("R7 empty count", int'(free_count), 0);
    @(negedge clk);
    ren_valid = 1'b1; ren_arch = 5'd4;
    #2 check("R10 ready low", int'(ren_ready), 0);
    @(posedge clk);
    #1 ren_valid = 1'b0;
    lookup_chk("R10 table kept", 4, 13);
    check("R10 count kept", int'(free_count), 0);
    @(negedge clk);
    ren_arch = 5'd9;
    #2 check("R10 fp still ready", int'(ren_ready), 1);
    ren_arch = 5'd0;
    #1 check("R10 zero still ready", int'(ren_ready), 1);
    // free physical 8, then 3
    @(negedge clk);
    ren_arch = 5'd4; free_int_valid = 1'b1; free_int_phys = 6'd8;
    #2 check("R12 not before edge", int'(ren_ready), 0);
    @(posedge clk);
    #1 free_int_phys = 6'd3;
    @(negedge clk);
    #2 check("R12 ready after free", int'(ren_ready), 1);
    check("R12 freed head", int'(ren_new), 8);
    @(posedge clk);
    #1 free_int_valid = 1'b0;
    check("R7 min after refill", int'(free_count), 2);
    rename_chk("R12 fifo first", 4, 8, 13);
    rename_chk("R12 fifo second", 5, 3, 14);
  endtask

  initial begin
    rst_n = 1'b0;
    ren_valid = 1'b0; set_valid = 1'b0; free_int_valid = 1'b0; free_fp_valid = 1'b0;
    ren_arch = '0; lk_arch = '0; set_arch = '0; set_phys = '0;
    free_int_phys = '0; free_fp_phys = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_int_rename();
    t_fp_rename();
    t_zero();
    t_misc();
    t_bad();
    t_set();
    t_drain_refill();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule